// File: doc/BRIEF.md
# Baud-Framed Dual-Sample Receive Deserializer

This block sits on the host side of a serial sample link. The far end sends one frame per baud period, and each frame is 48 ticks of an oversampling clock long. The block recovers two 16-bit samples from every frame. The first is the main sample. The second is an interpolated sample that follows an 8-tick gap. Each sample is presented as a parallel word together with a one-cycle valid pulse.

The block runs on a fast system clock. A `tick_en` input marks each rising edge of the oversampling clock. The baud strobe and the serial data are sampled only on those enabled cycles. A fall of the baud strobe, seen between two consecutive ticks, marks slot 1 of a new frame. Bits arrive MSB first. Gap slots and trailing slots never reach the word registers. A strobe that falls before all 48 slots have been counted restarts the frame and raises a one-cycle frame-error pulse.

Top module: `baud_dual_deser`

## Requirements
- R1: While `rst_n` is low, `word_a` and `word_b` are zero and `valid_a`, `valid_b` and `frame_err` are low.
- R2: Inputs are sampled only in cycles with `tick_en` high. Slot 1 of a frame is the tick on which `baud_strobe` is low after being high on the previous tick, and each later tick advances the slot by one. Data changes in cycles without `tick_en` have no effect on any output.
- R3: The bits of slots 1 to 16 form `word_a`, with slot 1 as bit 15 (MSB) and slot 16 as bit 0. `word_a` and `valid_a` update in the clock cycle right after the slot-16 tick.
- R4: The bits of slots 25 to 40 form `word_b`, with slot 25 as bit 15 and slot 40 as bit 0. `word_b` and `valid_b` update in the clock cycle right after the slot-40 tick.
- R5: The bits received in gap slots 17 to 24 and in trailing slots 41 to 48 have no effect on `word_a` or `word_b`.
- R6: `valid_a` and `valid_b` are each high for exactly one clock cycle per emitted word.
- R7: A strobe fall in slots 1 to 47 (early) raises `frame_err` for one clock cycle after that tick. That tick becomes slot 1 of a new frame, and the aborted frame emits no further word.
- R8: A strobe fall after slot 48 has been reached, or the first fall after reset, does not raise `frame_err`.
- R9: After slot 48, further ticks without a new strobe fall produce no valid pulse and no error.
- R10: `word_a` and `word_b` hold their last value between their valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable marking a rising edge of the oversampling clock |
| baud_strobe | input | 1 | Baud strobe; its fall starts a frame |
| ser_in | input | 1 | Serial sample data, MSB first |
| word_a | output | 16 | Last main sample |
| valid_a | output | 1 | One-cycle pulse when `word_a` updates |
| word_b | output | 16 | Last interpolated sample |
| valid_b | output | 1 | One-cycle pulse when `word_b` updates |
| frame_err | output | 1 | One-cycle pulse on an early strobe fall |

## Verification
The bench builds the block with its default parameters: 48 slots per baud, 16-bit words and an 8-slot gap. With these values every slot boundary is reachable: 16, 17, 24, 25, 40, 41 and 48. Ticks are spaced three system clocks apart, and the serial data is inverted in the cycles between ticks, so any sampling outside `tick_en` corrupts the words. Frames are also cut short at slot 30, and ticks are held past slot 48. These cases reach the restart path with its error pulse and the idle state after a full frame.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    // True when a slot number lies inside the closed window [first, last].
    function automatic logic slot_in_window(input int unsigned slot,
                                            input int unsigned first,
                                            input int unsigned last);
        return (slot >= first) && (slot <= last);
    endfunction
endpackage

// File: rtl/dsr_strobe_edge.sv
module dsr_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic strobe_in,
    output logic fall_o
);
    typedef struct packed {
        logic strobe;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            st_d.strobe = strobe_in;
        end
        fall_o = tick_en && st_q.strobe && !strobe_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dsr_slot_counter.sv
module dsr_slot_counter #(
    parameter int SLOTS = 48,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             fall_i,
    output logic [CNT_W-1:0] slot_o,
    output logic             early_o
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic running;

    always_comb begin
        st_d    = st_q;
        running = (st_q.cnt != '0) && (st_q.cnt < LAST_SLOT);
        early_o = fall_i && running;
        if (fall_i) begin
            slot_o = ONE;
        end else if (tick_en && running) begin
            slot_o = st_q.cnt + ONE;
        end else begin
            slot_o = '0;
        end
        if (slot_o != '0) begin
            st_d.cnt = slot_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dsr_word_shifter.sv
module dsr_word_shifter
    import dsr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int FIRST  = 1,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CNT_W-1:0]  slot_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int               LAST   = FIRST + WORD_W - 1;
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(LAST);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
        logic              valid;
    } sh_t;

    sh_t  st_d, st_q;
    logic take;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        take = tick_en && slot_in_window(int'(slot_i), FIRST, LAST);
        if (take) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], bit_i};
            if (slot_i == LAST_S) begin
                st_d.word  = {st_q.shreg[WORD_W-2:0], bit_i};
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/baud_dual_deser.sv
module baud_dual_deser #(
    parameter int SLOTS  = 48,
    parameter int WORD_W = 16,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              baud_strobe,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_a,
    output logic              valid_a,
    output logic [WORD_W-1:0] word_b,
    output logic              valid_b,
    output logic              frame_err
);
    localparam int CNT_W   = $clog2(SLOTS + 1);
    localparam int N_WORDS = 2;

    typedef struct packed {
        logic err;
    } top_t;

    top_t             st_d, st_q;
    logic             fall;
    logic             early;
    logic [CNT_W-1:0] slot;
    logic [WORD_W-1:0] words  [N_WORDS];
    logic              valids [N_WORDS];

    dsr_strobe_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .strobe_in (baud_strobe),
        .fall_o    (fall)
    );

    dsr_slot_counter #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .fall_i  (fall),
        .slot_o  (slot),
        .early_o (early)
    );

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        localparam int FIRST_SLOT = 1 + k * (WORD_W + GAP_W);
        dsr_word_shifter #(
            .WORD_W (WORD_W),
            .FIRST  (FIRST_SLOT),
            .CNT_W  (CNT_W)
        ) u_sh (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .slot_i  (slot),
            .bit_i   (ser_in),
            .word_o  (words[k]),
            .valid_o (valids[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_a    = words[0];
    assign valid_a   = valids[0];
    assign word_b    = words[1];
    assign valid_b   = valids[1];
    assign frame_err = st_q.err;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [WORD_W-1:0] word_a,
    input logic              valid_a,
    input logic [WORD_W-1:0] word_b,
    input logic              valid_b,
    input logic              frame_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !valid_a && !valid_b && !frame_err); // R1
    AST_VALID_A_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) valid_a |-> $past(tick_en)); // R2
    AST_VALID_B_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) valid_b |-> $past(tick_en)); // R2
    AST_NO_DUAL_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(valid_a && valid_b)); // R4
    AST_VALID_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) valid_a |=> !valid_a); // R6
    AST_VALID_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) valid_b |=> !valid_b); // R6
    AST_ERR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> $past(tick_en)); // R7
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R7
    AST_WORD_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !valid_a |-> $stable(word_a)); // R10
    AST_WORD_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !valid_b |-> $stable(word_b)); // R10
endmodule

bind baud_dual_deser dsr_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .word_a    (word_a),
    .valid_a   (valid_a),
    .word_b    (word_b),
    .valid_b   (valid_b),
    .frame_err (frame_err)
);

// File: tb/tb_baud_dual_deser.sv
module tb_baud_dual_deser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        baud_strobe = 1'b0;
    logic        ser_in = 1'b0;
    logic [15:0] word_a, word_b;
    logic        valid_a, valid_b, frame_err;

    int total = 0;
    int bad = 0;
    int width_bad = 0;
    logic prev_va = 1'b0, prev_vb = 1'b0, prev_er = 1'b0;

    always #4 clk = ~clk;

    baud_dual_deser dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .baud_strobe(baud_strobe),
        .ser_in(ser_in), .word_a(word_a), .valid_a(valid_a), .word_b(word_b),
        .valid_b(valid_b), .frame_err(frame_err)
    );

    // Pulse-width monitor, sampled away from the active edge (R6, R7)
    always @(negedge clk) begin
        if ((valid_a && prev_va) || (valid_b && prev_vb) || (frame_err && prev_er))
            width_bad++;
        prev_va <= valid_a;
        prev_vb <= valid_b;
        prev_er <= frame_err;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One oversampling tick; ser_in is inverted on the idle cycles around it.
    task automatic do_tick(input logic strobe, input logic b,
                           output logic va, output logic vb, output logic er);
        @(negedge clk);
        tick_en = 1'b1; baud_strobe = strobe; ser_in = b;
        @(negedge clk);
        tick_en = 1'b0; ser_in = ~b;
        va = valid_a; vb = valid_b; er = frame_err;
        @(negedge clk);
    endtask

    // Sends nslots slots of a frame; strobe low in slots 1..24, high after.
    task automatic run_frame(input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] gap, input int nslots,
                             input bit exp_err, input string tag);
        logic va, vb, er, bitv;
        int pulse_bad = 0;
        int err_bad = 0;
        for (int s = 1; s <= nslots; s++) begin
            if (s <= 16) bitv = a[16-s];
            else if (s >= 25 && s <= 40) bitv = b[40-s];
            else bitv = gap[s % 16];
            do_tick(s > 24, bitv, va, vb, er);
            if (va != (s == 16) || vb != (s == 40)) pulse_bad++;
            if (er != ((s == 1) && exp_err)) err_bad++;
            if (s == 16) chk(word_a == a, "R3", {tag, " word_a"}, word_a, a);
            if (s == 40) chk(word_b == b, "R4", {tag, " word_b"}, word_b, b);
        end
        chk(pulse_bad == 0, "R3", {tag, " valid slot timing"}, pulse_bad, 0);
        chk(err_bad == 0, exp_err ? "R7" : "R8", {tag, " frame_err"}, err_bad, 0);
    endtask

    task automatic preamble();
        logic va, vb, er;
        do_tick(1'b1, 1'b0, va, vb, er);
    endtask

    task automatic t_reset();
        #1;
        chk(word_a == 0 && word_b == 0, "R1", "words in reset", {word_a, word_b}, 0);
        chk(!valid_a && !valid_b && !frame_err, "R1", "flags in reset",
            {valid_a, valid_b, frame_err}, 0);
    endtask

    task automatic t_basic();
        preamble();
        run_frame(16'hA5C3, 16'h1234, 16'h0000, 48, 1'b0, "basic1 R2");
        run_frame(16'h0001, 16'h8000, 16'hFFFF, 48, 1'b0, "basic2 R2");
        run_frame(16'hFFFF, 16'h0000, 16'h5A5A, 48, 1'b0, "basic3");
        chk(word_a == 16'hFFFF, "R10", "word_a held after frame", word_a, 16'hFFFF);
    endtask

    task automatic t_gap();
        logic [15:0] ra, rb;
        run_frame(16'h3C96, 16'hE71B, 16'h0000, 48, 1'b0, "gap0");
        ra = word_a; rb = word_b;
        run_frame(16'h3C96, 16'hE71B, 16'hFFFF, 48, 1'b0, "gap1");
        chk(word_a == ra && word_b == rb, "R5", "gap bits ignored",
            {word_a, word_b}, {ra, rb});
    endtask

    task automatic t_early();
        logic [15:0] old_b;
        old_b = word_b;
        run_frame(16'h1357, 16'hFACE, 16'hAAAA, 30, 1'b0, "short");
        chk(word_b == old_b, "R7", "aborted frame emits no word_b", word_b, old_b);
        run_frame(16'h2468, 16'hBEEF, 16'h5555, 48, 1'b1, "restart R7");
    endtask

    task automatic t_idle_after();
        logic va, vb, er;
        int extra = 0;
        for (int i = 0; i < 10; i++) begin
            do_tick(1'b1, i[0], va, vb, er);
            if (va || vb || er) extra++;
        end
        chk(extra == 0, "R9", "ticks after slot 48 silent", extra, 0);
        run_frame(16'h0F0F, 16'hC001, 16'h0000, 48, 1'b0, "after idle R8");
    endtask

    task automatic finish_run();
        chk(width_bad == 0, "R6", "pulse width", width_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_gap();
        t_early();
        t_idle_after();
        finish_run();
    end
endmodule